// File: doc/BRIEF.md
# Restartable Iterative Integer Divider

A 32-bit divide/modulo unit that a processor drives through a small register bus. Software writes a dividend and a divisor, waits a fixed number of clocks, then reads the quotient and the remainder. Each operand has two write addresses. The address used for the most recent operand write selects a signed or an unsigned calculation. Every operand write starts the calculation again, using the stored value of the other operand.

All state can be saved and restored. Software can read both operands and both results. It can also write both results. Two flags handle nesting. DIRTY means that someone has touched the unit since the quotient was last read. READY means that the result registers hold a finished answer. An interrupt handler that finds DIRTY set waits for READY, saves the four values, and runs its own division. It then restores the interrupted state: it writes the operands, writes the remainder (which stops the calculation that the operand writes started), and writes the quotient last.

Inside, a radix-4 restoring engine produces four quotient bits per clock. It runs two radix-4 stages per cycle for eight cycles. The engine works on magnitudes, and on its last cycle it restores the signs of the quotient and remainder.

Top module: `restart_divider`

## Requirements
- R1: After an unsigned operand write (dividend at address 0, divisor at address 1), the quotient (address 4) and the remainder (address 5) read the unsigned results of dividend / divisor.
- R2: The control/status word sits at address 6, with bit 0 READY and bit 1 DIRTY. After reset it reads 1: READY set, DIRTY clear, and all data registers zero. READY reads 0 after each of the first seven clock edges that follow an operand-write edge. It reads 1 after the eighth edge, and the results are valid at that point.
- R3: Writing the dividend at address 2 or the divisor at address 3 gives a signed calculation. The quotient truncates toward zero, the remainder takes the sign of the dividend, and 0x80000000 / -1 gives quotient 0x80000000 and remainder 0.
- R4: Any operand write sets DIRTY and clears READY. It restarts the calculation with the latest stored operands, and a full eight-cycle latency begins again from that write.
- R5: A read of the quotient (address 4) clears DIRTY. A read of any other address leaves DIRTY unchanged.
- R6: Writing the remainder (address 5) stores the written value and stops any calculation in progress, so the engine never overwrites that value later. READY and DIRTY both read 1 afterwards.
- R7: Writing the quotient (address 4) stores the written value, stops any calculation in progress, and sets READY and DIRTY.
- R8: The stored dividend can be read at address 0 or 2, and the stored divisor at address 1 or 3, whichever alias wrote them. A register changes only when a bus write targets it.
- R9: Division by zero raises no fault and leaves the remainder equal to the dividend. The quotient is 0xFFFFFFFF for unsigned operation and for a non-negative signed dividend. It is 1 for a negative signed dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe; it matters only for the quotient address, where it clears DIRTY |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The RTL assertions check the flag rules on every cycle:
- an operand write clears READY and sets DIRTY;
- a result write stops the engine and sets both flags;
- a quotient read clears DIRTY;
- READY is never set while the engine is busy;
- the engine's completion always raises READY;
- the operand registers hold their values when no write occurs.

The assertions cannot see the arithmetic, the exact eight-edge latency, or the outcome of a save/restore sequence that interrupts a running division. The bench covers these with a behavioural reference model: it compares every register read against the model on each clock, and it runs scenarios for signed corners, division by zero, restarts and restores.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
   typedef enum logic [2:0] {
      A_UDVD = 3'd0,
      A_UDVS = 3'd1,
      A_SDVD = 3'd2,
      A_SDVS = 3'd3,
      A_QUO  = 3'd4,
      A_REM  = 3'd5,
      A_CSR  = 3'd6,
      A_NONE = 3'd7
   } rdiv_addr_e;

   localparam int CSR_READY_BIT = 0;
   localparam int CSR_DIRTY_BIT = 1;
endpackage

// File: rtl/rdiv_r4_step.sv
module rdiv_r4_step #(
   parameter int W = 32
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] quo_i,
   input  logic [W-1:0] dsr,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] num_o,
   output logic [W-1:0] quo_o
);
   logic [W+1:0] trial, d1, d2, d3;
   logic [1:0]   digit;

   always_comb begin
      trial = {rem_i, num_i[W-1 -: 2]};
      d1    = {2'b00, dsr};
      d2    = {1'b0, dsr, 1'b0};
      d3    = d1 + d2;
      // partial remainder is below the divisor, so the W-bit difference is exact
      if (trial >= d3) begin
         digit = 2'd3;
         rem_o = trial[W-1:0] - d3[W-1:0];
      end else if (trial >= d2) begin
         digit = 2'd2;
         rem_o = trial[W-1:0] - d2[W-1:0];
      end else if (trial >= d1) begin
         digit = 2'd1;
         rem_o = trial[W-1:0] - d1[W-1:0];
      end else begin
         digit = 2'd0;
         rem_o = trial[W-1:0];
      end
      num_o = {num_i[W-3:0], 2'b00};
      quo_o = {quo_i[W-3:0], digit};
   end
endmodule

// File: rtl/rdiv_engine.sv
module rdiv_engine #(
   parameter int W   = 32,
   parameter int LAT = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         stop,
   input  logic         is_signed,
   input  logic [W-1:0] dvd,
   input  logic [W-1:0] dvs,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quo_out,
   output logic [W-1:0] rem_out
);
   localparam int BPC   = W / LAT;
   localparam int STEPS = BPC / 2;
   localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LAT - 1);

   generate
      if (LAT < 2 || (W % LAT) != 0 || (BPC % 2) != 0 || BPC == 0) begin : g_bad_cfg
         $error("rdiv_engine: W must split into LAT cycles of an even bit count");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     rem_q, num_q, quo_q, dsr_q;
   logic             neg_q_q, neg_r_q;

   logic [W-1:0] c_rem [STEPS+1];
   logic [W-1:0] c_num [STEPS+1];
   logic [W-1:0] c_quo [STEPS+1];

   assign c_rem[0] = rem_q;
   assign c_num[0] = num_q;
   assign c_quo[0] = quo_q;

   generate
      for (genvar s = 0; s < STEPS; s++) begin : g_step
         rdiv_r4_step #(.W(W)) u_step (
            .rem_i (c_rem[s]),
            .num_i (c_num[s]),
            .quo_i (c_quo[s]),
            .dsr   (dsr_q),
            .rem_o (c_rem[s+1]),
            .num_o (c_num[s+1]),
            .quo_o (c_quo[s+1])
         );
      end
   endgenerate

   function automatic logic [W-1:0] mag(input logic [W-1:0] v, input logic sgn);
      return (sgn && v[W-1]) ? (~v + 1'b1) : v;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         rem_q   <= '0;
         num_q   <= '0;
         quo_q   <= '0;
         dsr_q   <= '0;
         neg_q_q <= 1'b0;
         neg_r_q <= 1'b0;
      end else if (stop) begin
         busy <= 1'b0;
      end else if (start) begin
         busy    <= 1'b1;
         cnt     <= '0;
         rem_q   <= '0;
         quo_q   <= '0;
         num_q   <= mag(dvd, is_signed);
         dsr_q   <= mag(dvs, is_signed);
         neg_q_q <= is_signed && (dvd[W-1] ^ dvs[W-1]);
         neg_r_q <= is_signed && dvd[W-1];
      end else if (busy) begin
         rem_q <= c_rem[STEPS];
         num_q <= c_num[STEPS];
         quo_q <= c_quo[STEPS];
         cnt   <= cnt + CNT_W'(1);
         if (cnt == LAST) busy <= 1'b0;
      end
   end

   assign done    = busy && (cnt == LAST) && !start && !stop;
   assign quo_out = neg_q_q ? (~c_quo[STEPS] + 1'b1) : c_quo[STEPS];
   assign rem_out = neg_r_q ? (~c_rem[STEPS] + 1'b1) : c_rem[STEPS];

   // R4: a start that is not cancelled leaves the engine busy
   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop) |=> busy);
   // R6: a stop leaves the engine idle
   p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !busy);
   // R2: completion ends the busy period
   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/restart_divider.sv
module restart_divider #(
   parameter int WIDTH   = 32,
   parameter int LATENCY = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [2:0]       bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata
);
   import rdiv_pkg::*;

   generate
      if (WIDTH < 4) begin : g_bad_width
         $error("restart_divider: WIDTH too small");
      end
   endgenerate

   logic [WIDTH-1:0] dvd_q, dvs_q, quo_q, rem_q;
   logic             ready_q, dirty_q;

   logic wr_dvd, wr_dvs, wr_quo, wr_rem, rd_quo;
   logic start, stop, sgn_sel;
   logic [WIDTH-1:0] dvd_nx, dvs_nx, eng_q, eng_r;
   logic eng_busy, eng_done;

   always_comb begin
      wr_dvd  = bus_wr && (bus_addr == A_UDVD || bus_addr == A_SDVD);
      wr_dvs  = bus_wr && (bus_addr == A_UDVS || bus_addr == A_SDVS);
      wr_quo  = bus_wr && (bus_addr == A_QUO);
      wr_rem  = bus_wr && (bus_addr == A_REM);
      rd_quo  = bus_rd && (bus_addr == A_QUO);
      start   = wr_dvd || wr_dvs;
      stop    = wr_quo || wr_rem;
      sgn_sel = (bus_addr == A_SDVD) || (bus_addr == A_SDVS);
      dvd_nx  = wr_dvd ? bus_wdata : dvd_q;
      dvs_nx  = wr_dvs ? bus_wdata : dvs_q;
   end

   rdiv_engine #(.W(WIDTH), .LAT(LATENCY)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .is_signed (sgn_sel),
      .dvd       (dvd_nx),
      .dvs       (dvs_nx),
      .busy      (eng_busy),
      .done      (eng_done),
      .quo_out   (eng_q),
      .rem_out   (eng_r)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvd_q   <= '0;
         dvs_q   <= '0;
         quo_q   <= '0;
         rem_q   <= '0;
         ready_q <= 1'b1;
         dirty_q <= 1'b0;
      end else begin
         dvd_q <= dvd_nx;
         dvs_q <= dvs_nx;
         if (wr_quo)        quo_q <= bus_wdata;
         else if (eng_done) quo_q <= eng_q;
         if (wr_rem)        rem_q <= bus_wdata;
         else if (eng_done) rem_q <= eng_r;
         if (stop)          ready_q <= 1'b1;
         else if (start)    ready_q <= 1'b0;
         else if (eng_done) ready_q <= 1'b1;
         if (rd_quo)           dirty_q <= 1'b0;
         if (start || stop)    dirty_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_UDVD, A_SDVD: bus_rdata = dvd_q;
         A_UDVS, A_SDVS: bus_rdata = dvs_q;
         A_QUO:          bus_rdata = quo_q;
         A_REM:          bus_rdata = rem_q;
         A_CSR: begin
            bus_rdata[CSR_READY_BIT] = ready_q;
            bus_rdata[CSR_DIRTY_BIT] = dirty_q;
         end
         default:        bus_rdata = '0;
      endcase
   end

   // R2: engine completion publishes READY
   p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> ready_q);
   // R2: READY never shows while the engine still runs
   p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !ready_q);
   // R4: operand write arms the flags
   p_opwr_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop) |=> (!ready_q && dirty_q && eng_busy));
   // R5: quotient read with no concurrent write clears DIRTY
   p_quo_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_quo && !bus_wr) |=> !dirty_q);
   // R6: remainder write stops the engine and sets both flags
   p_rem_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rem |=> (ready_q && dirty_q && !eng_busy && rem_q == $past(bus_wdata)));
   // R7: quotient write stops the engine and sets both flags
   p_quo_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_quo |=> (ready_q && dirty_q && !eng_busy && quo_q == $past(bus_wdata)));
   // R8: operands hold without a write
   p_ops_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(dvd_q) && $stable(dvs_q)));
endmodule

// File: tb/restart_divider_bench.sv
module restart_divider_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = 3'd6;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   restart_divider u_restart_divider (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   // reference model state
   logic [31:0] m_dvd, m_dvs, m_quo, m_rem;
   bit          m_ready, m_dirty, m_sgn;
   int          m_cnt;

   task automatic ref_div(input logic [31:0] n, input logic [31:0] d, input bit sgn,
                          output logic [31:0] q, output logic [31:0] r);
      longint sn, sd;
      if (d == 0) begin
         r = n;
         q = (sgn && n[31]) ? 32'd1 : 32'hFFFF_FFFF;
      end else if (!sgn) begin
         q = n / d;
         r = n % d;
      end else begin
         sn = longint'($signed(n));
         sd = longint'($signed(d));
         q = 32'(sn / sd);
         r = 32'(sn % sd);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dvd = 0; m_dvs = 0; m_quo = 0; m_rem = 0;
         m_ready = 1; m_dirty = 0; m_sgn = 0; m_cnt = 0;
      end else begin
         if (bus_rd && bus_addr == 3'd4) m_dirty = 0;
         if (bus_wr && bus_addr <= 3'd3) begin
            if (bus_addr[0]) m_dvs = bus_wdata; else m_dvd = bus_wdata;
            m_sgn = bus_addr[1];
            m_cnt = 8; m_ready = 0; m_dirty = 1;
         end else if (bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5)) begin
            if (bus_addr == 3'd4) m_quo = bus_wdata; else m_rem = bus_wdata;
            m_cnt = 0; m_ready = 1; m_dirty = 1;
         end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
               ref_div(m_dvd, m_dvs, m_sgn, m_quo, m_rem);
               m_ready = 1;
            end
         end
      end
   end

   function automatic logic [31:0] model_read(input logic [2:0] a);
      case (a)
         3'd0, 3'd2: return m_dvd;
         3'd1, 3'd3: return m_dvs;
         3'd4: return m_quo;
         3'd5: return m_rem;
         3'd6: return {30'd0, m_dirty, m_ready};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd4, 3'd5: return "R1";
         3'd6: return "R2";
         default: return "R8";
      endcase
   endfunction

   // every-clock comparison against the model
   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         checks++;
         if (bus_rdata !== model_read(bus_addr)) begin
            errors++;
            $display("FAIL %s per-cycle addr=%0d actual=%h expected=%h",
                     tag_of(bus_addr), bus_addr, bus_rdata, model_read(bus_addr));
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic op(input bit w, input bit r, input logic [2:0] a, input logic [31:0] d);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 0; bus_rd = 0; bus_addr = 3'd6;
   endtask

   task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a; #1;
      chk(tag, bus_rdata, exp);
      bus_addr = 3'd6;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic run_div(input logic [31:0] n, input logic [31:0] d, input bit sgn, input string tag);
      logic [31:0] q, r;
      op(1, 0, sgn ? 3'd2 : 3'd0, n);
      op(1, 0, sgn ? 3'd3 : 3'd1, d);
      idle(8);
      ref_div(n, d, sgn, q, r);
      peek(3'd4, q, {tag, " quotient"});
      peek(3'd5, r, {tag, " remainder"});
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R2 reset state
      peek(3'd6, 32'd1, "R2 reset csr");
      peek(3'd4, 32'd0, "R2 reset quotient");

      // R1 unsigned
      run_div(32'd100, 32'd7, 0, "R1 100/7");
      peek(3'd4, 32'd14, "R1 fixed quotient 14");
      run_div(32'hFFFF_FFFF, 32'd3, 0, "R1 max/3");
      run_div(32'h8000_0001, 32'h0001_0000, 0, "R1 large");

      // R3 signed
      run_div(-32'sd7, 32'sd2, 1, "R3 -7/2");
      peek(3'd4, 32'hFFFF_FFFD, "R3 quotient -3");
      peek(3'd5, 32'hFFFF_FFFF, "R3 remainder -1");
      run_div(32'sd7, -32'sd2, 1, "R3 7/-2");
      peek(3'd5, 32'd1, "R3 remainder +1");
      run_div(32'h8000_0000, 32'hFFFF_FFFF, 1, "R3 min/-1");
      peek(3'd4, 32'h8000_0000, "R3 min/-1 quotient");

      // R9 divide by zero
      run_div(32'd1234, 32'd0, 0, "R9 unsigned /0");
      peek(3'd4, 32'hFFFF_FFFF, "R9 unsigned quotient");
      run_div(-32'sd50, 32'd0, 1, "R9 signed neg /0");
      peek(3'd4, 32'd1, "R9 signed neg quotient");
      run_div(32'd50, 32'd0, 1, "R9 signed pos /0");

      // R2 exact latency
      op(1, 0, 3'd0, 32'd900);
      op(1, 0, 3'd1, 32'd30);
      for (int k = 1; k <= 8; k++) begin
         idle(1);
         peek(3'd6, (k < 8) ? 32'd2 : 32'd3, "R2 latency csr");
      end
      peek(3'd4, 32'd30, "R2 latency quotient");

      // R4 restart mid-flight, reusing stored divisor
      op(1, 0, 3'd0, 32'd1000);
      idle(3);
      op(1, 0, 3'd0, 32'd77);
      idle(7);
      peek(3'd6, 32'd2, "R4 restart still busy");
      idle(1);
      peek(3'd6, 32'd3, "R4 restart done");
      peek(3'd4, 32'd2, "R4 restart quotient 77/30");
      peek(3'd5, 32'd17, "R4 restart remainder");

      // R5 dirty rules
      op(0, 1, 3'd5, 32'd0);
      peek(3'd6, 32'd3, "R5 remainder read keeps dirty");
      op(0, 1, 3'd4, 32'd0);
      peek(3'd6, 32'd1, "R5 quotient read clears dirty");

      // R6 remainder write stops a running calculation
      op(1, 0, 3'd1, 32'd3);
      idle(3);
      op(1, 0, 3'd5, 32'h0000_0055);
      peek(3'd6, 32'd3, "R6 flags after remainder write");
      idle(10);
      peek(3'd5, 32'h0000_0055, "R6 remainder not overwritten");
      peek(3'd4, 32'd2, "R6 quotient not overwritten");

      // R7 quotient write
      op(0, 1, 3'd4, 32'd0);
      op(1, 0, 3'd0, 32'd500);
      idle(2);
      op(1, 0, 3'd4, 32'h0000_0077);
      peek(3'd6, 32'd3, "R7 flags after quotient write");
      idle(10);
      peek(3'd4, 32'h0000_0077, "R7 quotient held");

      // R8 readback through either alias
      op(1, 0, 3'd2, 32'hFFFF_FF00);
      peek(3'd0, 32'hFFFF_FF00, "R8 dividend via unsigned alias");
      peek(3'd2, 32'hFFFF_FF00, "R8 dividend via signed alias");
      op(1, 0, 3'd3, 32'h0000_0010);
      peek(3'd1, 32'h0000_0010, "R8 divisor via unsigned alias");
      op(1, 0, 3'd6, 32'hFFFF_FFFF);
      peek(3'd0, 32'hFFFF_FF00, "R8 dividend unchanged by other write");
      idle(9);
      peek(3'd4, 32'hFFFF_FFF0, "R3 -256/16 quotient");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule